// File: doc/BRIEF.md
# Power Mode and Clock Controller

This block decides how a small processor subsystem is clocked. Software writes an 8-bit control word. Bit 7 of that word is the idle-enable flag, and bits 1:0 request one of three oscillators: primary, secondary (a low-frequency timer oscillator) or internal. Each oscillator reports on a status pin whether it is running. The block switches to a requested source only while that source is running. Until then it keeps the old source and raises a pending flag.

A one-cycle sleep strobe takes the block out of Run. The idle-enable flag held in the register during the strobe cycle chooses between two low-power states. Idle stops only the CPU clock and leaves the peripherals clocked from the active source. Sleep stops every clock and deselects all sources. A wake pulse brings the block back to Run on the active source.

The outputs are a one-hot source select, a CPU clock enable, a peripheral clock enable and a 3-bit mode code that names one of seven modes. Every pin is a plain level or strobe. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in Run on the primary source: src_sel_o = 3'b001, both clock enables are 1, mode_o = 1, switch_pending_o = 0, and the idle flag is cleared.
- R2: The select field ctrl_wdata_i[1:0] maps as follows: 2'b10 and 2'b00 give primary, 2'b01 gives secondary, 2'b11 gives internal. In src_sel_o, bit 0 is primary, bit 1 is secondary and bit 2 is internal. Bits 6:2 of the written word have no effect.
- R3: If the requested oscillator's bit in osc_run_i (same bit order as src_sel_o) is 1 in the cycle of the write, src_sel_o changes at that same clock edge and switch_pending_o stays 0.
- R4: If the requested oscillator is not running, src_sel_o keeps the old source and switch_pending_o is 1. The switch completes, and the pending flag clears, at the first clock edge where that oscillator reports running.
- R5: A sleep strobe in Run while the stored idle flag is 0 enters Sleep at the next edge: mode_o = 0, both clock enables are 0, src_sel_o = 3'b000.
- R6: A sleep strobe in Run while the stored idle flag is 1 enters Idle: cpu_clk_en_o = 0, per_clk_en_o = 1, and src_sel_o shows the active source.
- R7: The low-power state is chosen by the idle flag as stored in the register during the strobe cycle. A write in the same cycle, or any later write, does not change a low-power state already entered.
- R8: In Run, cpu_clk_en_o and per_clk_en_o are both 1, and mode_o is 1, 2 or 3 for primary, secondary or internal.
- R9: A wake pulse in Idle or Sleep returns the block to Run on the active source at the next edge. A wake pulse in Run has no effect.
- R10: A sleep strobe in Idle or Sleep is ignored. When wake and sleep arrive in the same cycle while the block is in a low-power state, wake wins and the block returns to Run.
- R11: The Idle mode code is 5, 6 or 7 for primary, secondary or internal, which is the Run code plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control word: bit 7 idle-enable, bits 1:0 source select |
| sleep_i | input | 1 | One-cycle strobe requesting a low-power state |
| wake_i | input | 1 | Wake event pulse |
| osc_run_i | input | 3 | Oscillator running flags: bit 0 primary, bit 1 secondary, bit 2 internal |
| src_sel_o | output | 3 | One-hot active source; all zero in Sleep |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| mode_o | output | 3 | Mode code: 0 Sleep, 1-3 Run, 5-7 Idle |
| switch_pending_o | output | 1 | A requested source is waiting for its oscillator |

## Verification
Two collisions matter here. The first is a control-register write that changes the idle flag in the same cycle as the sleep strobe. The bench drives both on one edge and expects the state chosen by the flag's old value; it then checks that later writes leave that state unchanged. The second is a wake pulse coinciding with a sleep strobe while in a low-power state. The bench expects Run on the next edge and checks the mode code and both clock enables.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned SRC_N   = 3;
  localparam int unsigned SRC_PRI = 0;
  localparam int unsigned SRC_SEC = 1;
  localparam int unsigned SRC_RC  = 2;
  localparam int unsigned MODE_W  = 3;

  typedef logic [SRC_N-1:0] src_oh_t;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_SLEEP = 2'd2
  } pm_state_e;

  localparam logic [MODE_W-1:0] MODE_SLEEP = 3'd0;
  localparam logic [MODE_W-1:0] MODE_RUN0  = 3'd1;
  localparam logic [MODE_W-1:0] MODE_IDLE0 = 3'd5;

  localparam src_oh_t SRC_RESET = src_oh_t'(1) << SRC_PRI;

  // Select code to one-hot source; the unused code falls back to primary.
  function automatic src_oh_t sel_decode(input logic [1:0] code);
    src_oh_t oh;
    case (code)
      2'b01:   oh = src_oh_t'(1) << SRC_SEC;
      2'b11:   oh = src_oh_t'(1) << SRC_RC;
      default: oh = src_oh_t'(1) << SRC_PRI;
    endcase
    return oh;
  endfunction

  function automatic logic [1:0] src_index(input src_oh_t oh);
    logic [1:0] idx;
    idx = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (oh[i]) idx = 2'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
  import pmc_pkg::*;
#(
  parameter int unsigned CTRL_W   = 8,
  parameter int unsigned IDLE_BIT = 7,
  parameter int unsigned SEL_LSB  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic              idle_q_o,
  output src_oh_t           req_q_o,
  output src_oh_t           req_nxt_o
);
  logic    idle_q;
  src_oh_t req_q;

  // The request seen by the source switch already includes this cycle's write.
  always_comb begin
    req_nxt_o = we_i ? sel_decode(wdata_i[SEL_LSB +: 2]) : req_q;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      idle_q <= 1'b0;
      req_q  <= SRC_RESET;
    end else if (we_i) begin
      idle_q <= wdata_i[IDLE_BIT];
      req_q  <= req_nxt_o;
    end
  end

  assign idle_q_o = idle_q;
  assign req_q_o  = req_q;

  p_idle_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(idle_q));
endmodule

// File: rtl/pmc_src_switch.sv
module pmc_src_switch
  import pmc_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  src_oh_t        req_q_i,
  input  src_oh_t        req_nxt_i,
  input  logic [SRC_N-1:0] osc_run_i,
  output src_oh_t        active_o,
  output logic           pending_o
);
  src_oh_t active_q;
  logic    req_ready;

  assign req_ready = |(req_nxt_i & osc_run_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      active_q <= SRC_RESET;
    end else if (req_ready) begin
      active_q <= req_nxt_i;
    end
  end

  assign active_o  = active_q;
  assign pending_o = |(req_q_i ^ active_q);

  p_switch_needs_osc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q != $past(active_q)) |-> |(active_q & $past(osc_run_i)));

  p_pending_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && !we_i && !(|(req_q_i & osc_run_i))) |=> $stable(active_q));

  p_pending_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && !we_i && |(req_q_i & osc_run_i)) |=> !pending_o);
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sleep_i,
  input  logic      wake_i,
  input  logic      idle_q_i,
  output pm_state_e state_o
);
  pm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PM_RUN:   if (sleep_i) state_d = idle_q_i ? PM_IDLE : PM_SLEEP;
      PM_IDLE,
      PM_SLEEP: if (wake_i) state_d = PM_RUN;
      default:  state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) state_q <= PM_RUN;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  p_enter_sleep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_RUN && sleep_i && !idle_q_i) |=> (state_q == PM_SLEEP));

  p_enter_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_RUN && sleep_i && idle_q_i) |=> (state_q == PM_IDLE));

  p_wake_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != PM_RUN && wake_i) |=> (state_q == PM_RUN));

  p_lowpower_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != PM_RUN && !wake_i) |=> $stable(state_q));
endmodule

// File: rtl/pmc_out_dec.sv
module pmc_out_dec
  import pmc_pkg::*;
(
  input  pm_state_e          state_i,
  input  src_oh_t            active_i,
  output src_oh_t            src_sel_o,
  output logic               cpu_en_o,
  output logic               per_en_o,
  output logic [MODE_W-1:0]  mode_o
);
  logic [MODE_W-1:0] src_off;

  assign src_off = MODE_W'(src_index(active_i));

  always_comb begin
    src_sel_o = active_i;
    cpu_en_o  = 1'b1;
    per_en_o  = 1'b1;
    mode_o    = MODE_RUN0 + src_off;
    case (state_i)
      PM_IDLE: begin
        cpu_en_o = 1'b0;
        mode_o   = MODE_IDLE0 + src_off;
      end
      PM_SLEEP: begin
        src_sel_o = '0;
        cpu_en_o  = 1'b0;
        per_en_o  = 1'b0;
        mode_o    = MODE_SLEEP;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned CTRL_W   = 8,
  parameter int unsigned IDLE_BIT = 7,
  parameter int unsigned SEL_LSB  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              sleep_i,
  input  logic              wake_i,
  input  logic [2:0]        osc_run_i,
  output logic [2:0]        src_sel_o,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic [2:0]        mode_o,
  output logic              switch_pending_o
);
  logic      idle_q;
  src_oh_t   req_q, req_nxt, active;
  pm_state_e state;

  pmc_ctrl_reg #(
    .CTRL_W   (CTRL_W),
    .IDLE_BIT (IDLE_BIT),
    .SEL_LSB  (SEL_LSB)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctrl_we_i),
    .wdata_i   (ctrl_wdata_i),
    .idle_q_o  (idle_q),
    .req_q_o   (req_q),
    .req_nxt_o (req_nxt)
  );

  pmc_src_switch u_switch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctrl_we_i),
    .req_q_i   (req_q),
    .req_nxt_i (req_nxt),
    .osc_run_i (osc_run_i),
    .active_o  (active),
    .pending_o (switch_pending_o)
  );

  pmc_mode_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sleep_i  (sleep_i),
    .wake_i   (wake_i),
    .idle_q_i (idle_q),
    .state_o  (state)
  );

  pmc_out_dec u_dec (
    .state_i   (state),
    .active_i  (active),
    .src_sel_o (src_sel_o),
    .cpu_en_o  (cpu_clk_en_o),
    .per_en_o  (per_clk_en_o),
    .mode_o    (mode_o)
  );

  p_cpu_needs_per_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o |-> per_clk_en_o);

  p_sel_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_clk_en_o |-> $onehot(src_sel_o));

  p_sleep_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !per_clk_en_o |-> (src_sel_o == 3'b000 && mode_o == 3'd0));
endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic       sleep = 1'b0;
  logic       wake = 1'b0;
  logic [2:0] osc_run = 3'b111;
  logic [2:0] src_sel;
  logic       cpu_en, per_en, pending;
  logic [2:0] mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl dut_i (
    .clk_i            (clk),
    .rst_ni           (rst_ni),
    .ctrl_we_i        (ctrl_we),
    .ctrl_wdata_i     (ctrl_wdata),
    .sleep_i          (sleep),
    .wake_i           (wake),
    .osc_run_i        (osc_run),
    .src_sel_o        (src_sel),
    .cpu_clk_en_o     (cpu_en),
    .per_clk_en_o     (per_en),
    .mode_o           (mode),
    .switch_pending_o (pending)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [2:0] e_sel, input logic e_cpu,
                         input logic e_per, input logic [2:0] e_mode);
    chk(req, "src_sel", {5'd0, src_sel}, {5'd0, e_sel});
    chk(req, "cpu_en",  {7'd0, cpu_en},  {7'd0, e_cpu});
    chk(req, "per_en",  {7'd0, per_en},  {7'd0, e_per});
    chk(req, "mode",    {5'd0, mode},    {5'd0, e_mode});
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    ctrl_we = 1'b1; ctrl_wdata = d;
    cyc();
    ctrl_we = 1'b0;
  endtask

  task automatic pulse_sleep();
    sleep = 1'b1; cyc(); sleep = 1'b0;
  endtask

  task automatic pulse_wake();
    wake = 1'b1; cyc(); wake = 1'b0;
  endtask

  task automatic t_reset();
    chk_out("R1", 3'b001, 1'b1, 1'b1, 3'd1);
    chk("R1", "pending", {7'd0, pending}, 8'd0);
  endtask

  task automatic t_codes();
    osc_run = 3'b111;
    wr(8'h01); chk_out("R2", 3'b010, 1'b1, 1'b1, 3'd2);
    chk("R3", "pending", {7'd0, pending}, 8'd0);
    wr(8'h03); chk_out("R2", 3'b100, 1'b1, 1'b1, 3'd3);
    wr(8'h00); chk_out("R2", 3'b001, 1'b1, 1'b1, 3'd1);
    wr(8'h7D); chk_out("R2", 3'b010, 1'b1, 1'b1, 3'd2);
    wr(8'h02); chk_out("R8", 3'b001, 1'b1, 1'b1, 3'd1);
  endtask

  task automatic t_pending();
    osc_run = 3'b001;
    wr(8'h03);
    chk_out("R4", 3'b001, 1'b1, 1'b1, 3'd1);
    chk("R4", "pending set", {7'd0, pending}, 8'd1);
    repeat (3) cyc();
    chk("R4", "held src", {5'd0, src_sel}, 8'h01);
    osc_run = 3'b101;
    cyc();
    chk_out("R4", 3'b100, 1'b1, 1'b1, 3'd3);
    chk("R4", "pending clear", {7'd0, pending}, 8'd0);
    osc_run = 3'b111;
    wr(8'h02);
    chk("R3", "back to primary", {5'd0, src_sel}, 8'h01);
  endtask

  task automatic t_sleep();
    pulse_sleep();
    chk_out("R5", 3'b000, 1'b0, 1'b0, 3'd0);
    wr(8'h82); cyc();
    chk("R7", "mode after write", {5'd0, mode}, 8'd0);
    pulse_sleep();
    chk("R10", "sleep in sleep", {5'd0, mode}, 8'd0);
    pulse_wake();
    chk_out("R9", 3'b001, 1'b1, 1'b1, 3'd1);
  endtask

  task automatic t_idle();
    wr(8'h81);
    pulse_sleep();
    chk_out("R6", 3'b010, 1'b0, 1'b1, 3'd6);
    pulse_sleep();
    chk("R10", "sleep in idle", {5'd0, mode}, 8'd6);
    wr(8'h01);
    chk("R7", "mode after write", {5'd0, mode}, 8'd6);
    pulse_wake();
    chk_out("R9", 3'b010, 1'b1, 1'b1, 3'd2);
  endtask

  task automatic t_same_cycle();
    ctrl_we = 1'b1; ctrl_wdata = 8'h81; sleep = 1'b1;
    cyc();
    ctrl_we = 1'b0; sleep = 1'b0;
    chk_out("R7", 3'b000, 1'b0, 1'b0, 3'd0);
    wake = 1'b1; sleep = 1'b1;
    cyc();
    wake = 1'b0; sleep = 1'b0;
    chk_out("R10", 3'b010, 1'b1, 1'b1, 3'd2);
    pulse_wake();
    chk_out("R9", 3'b010, 1'b1, 1'b1, 3'd2);
  endtask

  task automatic t_idle_codes();
    wr(8'h83);
    pulse_sleep();
    chk_out("R11", 3'b100, 1'b0, 1'b1, 3'd7);
    pulse_wake();
    wr(8'h82);
    pulse_sleep();
    chk_out("R11", 3'b001, 1'b0, 1'b1, 3'd5);
    pulse_wake();
    chk_out("R8", 3'b001, 1'b1, 1'b1, 3'd1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    cyc();
    t_reset();
    t_codes();
    t_pending();
    t_sleep();
    t_idle();
    t_same_cycle();
    t_idle_codes();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule